// File: doc/BRIEF.md
# Bus START/STOP Condition Qualifier

This block watches a two-wire serial bus (clock line SCL, data line SDA) on the system clock. It reports START and STOP conditions only when their timing holds up. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Each candidate must pass three minimums, all measured in system-clock cycles:

- **Setup:** how long SCL was high before the SDA edge.
- **Hold:** how long SCL stays high from the SDA edge on.
- **Release:** how long SCL has been high in total.

A mode input chooses between a standard limit set and a faster one.

Each qualified condition gives a one-cycle pulse. A qualified START sets a bus-busy flag and a qualified STOP clears it. A STOP seen while the port is a slave (`master_i` low) raises a sticky interrupt request. Software clears that request with a pulse on `irq_clr_i`.

Top module: `bus_cond_qualifier`

## Requirements
- R1: After reset `start_o`, `stop_o`, `busy_o` and `irq_o` are all low.
- R2: A START is accepted when all of the following hold for the synchronised SDA fall with synchronised SCL high:
  - SCL was high for more than the setup limit of cycles before the edge.
  - SCL stays high for more than the hold limit of cycles counting the edge cycle.
  - SCL's total high time exceeds the release limit.
  Once accepted, `start_o` pulses for exactly one cycle, one cycle after the hold limit is exceeded.
- R3: A STOP is qualified the same way on an SDA rise and pulses `stop_o` for one cycle.
- R4: The limits are selected by `fast_mode_i`:

  | `fast_mode_i` | Release | Setup | Hold |
  |---|---|---|---|
  | 0 | 26 | 13 | 13 |
  | 1 | 4 | 2 | 2 |

  "Exceeds" means strictly greater.
- R5: A candidate whose setup count does not exceed the setup limit is discarded with no pulse.
- R6: A candidate is discarded with no pulse if SCL falls before the hold limit is exceeded.
- R7: A second SDA edge during the hold window discards the candidate, and neither pulse is issued.
- R8: SDA transitions while SCL is low produce no pulse.
- R9: `busy_o` rises with a START pulse and falls with a STOP pulse, and holds otherwise.
- R10: The interrupt request:
  - A STOP pulse with `master_i` low sets `irq_o`.
  - A STOP with `master_i` high leaves `irq_o` unchanged.
  - `irq_o` stays high until `irq_clr_i` is pulsed; a set in the same cycle wins over a clear.
- R11: The cycle counters saturate, so a START following an SCL-high period of hundreds of cycles is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| fast_mode_i | input | 1 | 1 selects the fast limit set |
| master_i | input | 1 | 1 when the port acts as bus master |
| irq_clr_i | input | 1 | Clears the interrupt request |
| start_o | output | 1 | One-cycle pulse on a qualified START |
| stop_o | output | 1 | One-cycle pulse on a qualified STOP |
| busy_o | output | 1 | Bus is between START and STOP |
| irq_o | output | 1 | Sticky STOP-in-slave-mode interrupt |

## Verification
SCL and SDA reach the counters two cycles after they change at the pins. A START or STOP pulse therefore appears three cycles after the input cycle in which SCL has been high for hold-limit-plus-one cycles since the SDA edge. `busy_o` and `irq_o` change in the same cycle as that pulse. The bench reference model reproduces the two-cycle pin delay and these counts with integers, and it updates on the same edge as the design. Outputs are compared half a cycle later, on every cycle, so every pulse is checked in exactly its due cycle. Scenario checks then count pulses after each bus pattern has settled for six cycles.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  typedef enum logic {ST_IDLE, ST_HOLD} qstate_e;
  typedef enum logic {EV_START, EV_STOP} ev_e;
endpackage

// File: rtl/bcq_sync.sv
module bcq_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/bcq_sat_cnt.sv
module bcq_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && inc_i && !clr_i) |=> (cnt_o == MAX)); // R11
endmodule

// File: rtl/bcq_qualifier.sv
module bcq_qualifier
  import bcq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic [CNT_W-1:0] rel_min_i,
  input  logic [CNT_W-1:0] su_min_i,
  input  logic [CNT_W-1:0] hd_min_i,
  input  logic             master_i,
  input  logic             irq_clr_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             busy_o,
  output logic             irq_o
);
  qstate_e state_q, state_n;
  ev_e     ev_q, ev_n;
  logic    sda_d_q, sda_edge;
  logic    hold_inc, emit_start, emit_stop;
  logic    start_q, stop_q, busy_q, irq_q;
  logic [CNT_W-1:0] hi_cnt, hd_cnt;

  assign sda_edge = sda_d_q ^ sda_s_i;

  // time SCL has been high (release / setup measure)
  bcq_sat_cnt #(.W(CNT_W)) u_rel_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (!scl_s_i), .inc_i (scl_s_i),
    .cnt_o (hi_cnt)
  );

  // hold measure, counts the edge cycle
  bcq_sat_cnt #(.W(CNT_W)) u_hold_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (!hold_inc), .inc_i (hold_inc),
    .cnt_o (hd_cnt)
  );

  always_comb begin
    state_n    = state_q;
    ev_n       = ev_q;
    hold_inc   = 1'b0;
    emit_start = 1'b0;
    emit_stop  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (scl_s_i && sda_edge && hi_cnt > su_min_i) begin
          state_n  = ST_HOLD;
          ev_n     = sda_s_i ? EV_STOP : EV_START;
          hold_inc = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!scl_s_i || sda_edge) begin
          state_n = ST_IDLE;
        end else if (hd_cnt >= hd_min_i && hi_cnt > rel_min_i) begin
          state_n    = ST_IDLE;
          emit_start = (ev_q == EV_START);
          emit_stop  = (ev_q == EV_STOP);
        end else begin
          hold_inc = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ev_q    <= EV_START;
      sda_d_q <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ev_q    <= ev_n;
      sda_d_q <= sda_s_i;
      start_q <= emit_start;
      stop_q  <= emit_stop;
      if (emit_start)     busy_q <= 1'b1;
      else if (emit_stop) busy_q <= 1'b0;
      if (emit_stop && !master_i) irq_q <= 1'b1;
      else if (irq_clr_i)         irq_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign busy_o  = busy_q;
  assign irq_o   = irq_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o); // R9
  AST_STOP_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o); // R9
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |=> !(start_o || stop_o)); // R2
  AST_SCL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> $past(scl_s_i)); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o); // R10
  AST_IRQ_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (stop_o && !$past(master_i))); // R10
endmodule

// File: rtl/bus_cond_qualifier.sv
module bus_cond_qualifier #(
  parameter int CNT_W   = 8,
  parameter int STD_REL = 26,
  parameter int STD_SU  = 13,
  parameter int STD_HD  = 13,
  parameter int FST_REL = 4,
  parameter int FST_SU  = 2,
  parameter int FST_HD  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic fast_mode_i,
  input  logic master_i,
  input  logic irq_clr_i,
  output logic start_o,
  output logic stop_o,
  output logic busy_o,
  output logic irq_o
);
  localparam logic [CNT_W-1:0] L_STD_REL = CNT_W'(STD_REL);
  localparam logic [CNT_W-1:0] L_STD_SU  = CNT_W'(STD_SU);
  localparam logic [CNT_W-1:0] L_STD_HD  = CNT_W'(STD_HD);
  localparam logic [CNT_W-1:0] L_FST_REL = CNT_W'(FST_REL);
  localparam logic [CNT_W-1:0] L_FST_SU  = CNT_W'(FST_SU);
  localparam logic [CNT_W-1:0] L_FST_HD  = CNT_W'(FST_HD);

  logic [1:0]       bus_s;
  logic [CNT_W-1:0] rel_min, su_min, hd_min;

  bcq_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  assign rel_min = fast_mode_i ? L_FST_REL : L_STD_REL;
  assign su_min  = fast_mode_i ? L_FST_SU  : L_STD_SU;
  assign hd_min  = fast_mode_i ? L_FST_HD  : L_STD_HD;

  bcq_qualifier #(.CNT_W(CNT_W)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .rel_min_i (rel_min),
    .su_min_i  (su_min),
    .hd_min_i  (hd_min),
    .master_i  (master_i),
    .irq_clr_i (irq_clr_i),
    .start_o   (start_o),
    .stop_o    (stop_o),
    .busy_o    (busy_o),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/bus_cond_qualifier_tb_top.sv
module bus_cond_qualifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, fast = 1'b0, master = 1'b0, irq_clr = 1'b0;
  logic start_o, stop_o, busy_o, irq_o;
  int   n_cmp = 0, n_err = 0, n_start = 0, n_stop = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  bus_cond_qualifier dut_i (
    .clk_i (clk), .rst_ni (rst_n), .scl_i (scl), .sda_i (sda),
    .fast_mode_i (fast), .master_i (master), .irq_clr_i (irq_clr),
    .start_o (start_o), .stop_o (stop_o), .busy_o (busy_o), .irq_o (irq_o)
  );

  // behavioural reference model
  int m_scl1, m_scl2, m_sda1, m_sda2, m_sdad, m_hi, m_hd, m_inhold, m_kind;
  int e_start, e_stop, e_busy, e_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1; m_sdad = 1;
      m_hi = 0; m_hd = 0; m_inhold = 0; m_kind = 0;
      e_start = 0; e_stop = 0; e_busy = 0; e_irq = 0;
    end else begin
      int rel, su, hd;
      bit edg;
      rel = fast ? 4 : 26;
      su  = fast ? 2 : 13;
      hd  = fast ? 2 : 13;
      edg = (m_sda2 != m_sdad);
      e_start = 0; e_stop = 0;
      if (m_inhold == 0) begin
        if (m_scl2 == 1 && edg && m_hi > su) begin
          m_inhold = 1; m_kind = m_sda2; m_hd = 1;
        end
      end else begin
        if (m_scl2 == 0 || edg) begin
          m_inhold = 0; m_hd = 0;
        end else if (m_hd >= hd && m_hi > rel) begin
          if (m_kind == 1) e_stop = 1; else e_start = 1;
          m_inhold = 0; m_hd = 0;
        end else begin
          m_hd = (m_hd < 255) ? m_hd + 1 : 255;
        end
      end
      if (e_start == 1) e_busy = 1;
      if (e_stop == 1)  e_busy = 0;
      if (e_stop == 1 && !master) e_irq = 1;
      else if (irq_clr)           e_irq = 0;
      m_hi = (m_scl2 == 1) ? ((m_hi < 255) ? m_hi + 1 : 255) : 0;
      m_sdad = m_sda2; m_sda2 = m_sda1; m_sda1 = sda;
      m_scl2 = m_scl1; m_scl1 = scl;
    end
  end

  task automatic cmp1(input string req, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp1("R2", "start_o", int'(start_o), e_start);
      cmp1("R3", "stop_o",  int'(stop_o),  e_stop);
      cmp1("R9", "busy_o",  int'(busy_o),  e_busy);
      cmp1("R10", "irq_o",  int'(irq_o),   e_irq);
      if (start_o) n_start++;
      if (stop_o)  n_stop++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    cmp1(req, "scenario", act, exp);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one condition: setup/hold in input cycles
  task automatic cond(input bit to_stop, input int su_c, input int hd_c);
    scl = 1'b0; ticks(2);
    sda = to_stop ? 1'b0 : 1'b1; ticks(2);
    scl = 1'b1; ticks(su_c);
    sda = ~sda; ticks(hd_c);
    scl = 1'b0; ticks(6);
  endtask

  initial begin
    int s0, p0;
    ticks(3);
    chk("R1", int'({start_o, stop_o, busy_o, irq_o}), 0);
    rst_n = 1'b1;
    ticks(4);
    chk("R1", int'({start_o, stop_o, busy_o, irq_o}), 0);

    s0 = n_start; cond(1'b0, 14, 14);
    chk("R2", n_start - s0, 1); chk("R9", int'(busy_o), 1);
    chk("R4", n_stop, 0);

    s0 = n_start; cond(1'b0, 13, 14);
    chk("R5", n_start - s0, 0);
    s0 = n_start; cond(1'b0, 14, 13);
    chk("R6", n_start - s0, 0);

    p0 = n_stop; cond(1'b1, 14, 14);
    chk("R3", n_stop - p0, 1); chk("R9", int'(busy_o), 0);
    chk("R10", int'(irq_o), 1);
    ticks(20);
    chk("R10", int'(irq_o), 1);
    irq_clr = 1'b1; ticks(1); irq_clr = 1'b0; ticks(2);
    chk("R10", int'(irq_o), 0);

    master = 1'b1;
    p0 = n_stop; cond(1'b1, 14, 14);
    chk("R10", n_stop - p0, 1); chk("R10", int'(irq_o), 0);
    master = 1'b0;

    s0 = n_start; p0 = n_stop;
    scl = 1'b0; ticks(3);
    for (int i = 0; i < 6; i++) begin sda = ~sda; ticks(5); end
    ticks(6);
    chk("R8", (n_start - s0) + (n_stop - p0), 0);

    sda = 1'b1; ticks(3); s0 = n_start; p0 = n_stop;
    scl = 1'b1; ticks(20); sda = 1'b0; ticks(3); sda = 1'b1; ticks(20);
    scl = 1'b0; ticks(6);
    chk("R7", (n_start - s0) + (n_stop - p0), 0);

    fast = 1'b1; ticks(2);
    s0 = n_start; cond(1'b0, 3, 3);
    chk("R4", n_start - s0, 1);
    s0 = n_start; cond(1'b0, 2, 3);
    chk("R5", n_start - s0, 0);
    s0 = n_start; cond(1'b0, 3, 2);
    chk("R6", n_start - s0, 0);
    p0 = n_stop; cond(1'b1, 3, 3);
    chk("R4", n_stop - p0, 1);
    fast = 1'b0; ticks(2);

    s0 = n_start; cond(1'b0, 400, 14);
    chk("R11", n_start - s0, 1);

    ticks(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule